// File: doc/BRIEF.md
# Uncore Event Counter Bank

This block is a bank of eight 48-bit event counters that software reaches through a simple register bus. Each counter picks one event from a 256-wide vector of single-cycle strobes, using an 8-bit code. A counter advances on a cycle where its chosen strobe is high, its own enable bit is set and the global run bit is set. Software can preset any counter at any time. When a counter wraps past its top value it sets a sticky per-counter overflow flag. A level interrupt is raised while any overflow flag is set whose mask bit is clear.

The bus takes a 16-bit byte address, a write flag and a width flag that selects a 32-bit or a 64-bit access. Writes take effect on the clock edge on which the request is presented. Read data is combinational from the address in the same cycle. Counters sit in 64-bit slots. A 32-bit access at slot offset +0 reaches counter bits 31:0, and a 32-bit access at offset +4 reaches counter bits 47:32.

Top module: `evcnt_bank`

## Requirements
- R1: After reset every counter reads 0, the control register (0x0408) and the enable register (0x1C00) read 0, the mask register (0x0800) reads 0xFF, both select registers (0x1D00, 0x1D04) read 0xFFFFFFFF, the status register (0x0808) reads 0 and irq_o is low.
- R2: Counter n sits at 0x1E00+8n. A 64-bit read returns the count with bits 63:48 as zero, and bits 63:48 of a 64-bit write are ignored. A 32-bit access at +0 reaches bits 31:0. A 32-bit access at +4 reaches bits 47:32, carried in data bits 15:0.
- R3: The event code of counter n is the byte at bits 8*(n mod 4)+7 down to 8*(n mod 4) of register 0x1D00 (for n < 4) or 0x1D04 (for n >= 4). An enabled counter adds one on each cycle in which evt_i[code] is high.
- R4: While bit 17 of 0x0408 is clear, no counter advances, whatever its enable bit is.
- R5: Bit n of 0x1C00 enables counter n. A counter whose enable bit is clear does not advance.
- R6: A counter whose code is 0xFF never advances, even when evt_i[255] is high.
- R7: An increment from 2^48-1 gives 0 and sets bit n of the status register 0x0808 on the same edge.
- R8: Writing 0x080C clears each status bit whose data bit is 1 and leaves the bits written 0 unchanged. An overflow on the same edge as a clear of its bit leaves that bit set.
- R9: irq_o is high exactly when some status bit n is set while bit n of 0x0800 is 0. A mask bit of 1 masks counter n.
- R10: A software write to a counter on the same edge as one of its events loads the written value, and that event is not counted.
- R11: Reads of addresses that map to no register, including 0x080C and counter slots at or beyond 0x1E40, return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_valid_i | input | 1 | Request present this cycle |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_wide_i | input | 1 | 1 = 64-bit access, 0 = 32-bit access |
| bus_addr_i | input | 16 | Byte address |
| bus_wdata_i | input | 64 | Write data (bits 31:0 for 32-bit access) |
| bus_rdata_o | output | 64 | Read data for the presented address |
| evt_i | input | 256 | Single-cycle event strobes, indexed by event code |
| irq_o | output | 1 | Level overflow interrupt |

## Verification
The counting path is driven with several patterns. One uses distinct codes on counters in both select registers, which separates byte lanes and registers that were swapped. One strobes every event at once, which shows that code 0xFF stays idle while the other counters keep moving. Others strobe with the run bit clear or with an enable bit clear, which tells the global gate apart from the per-counter gate. Presets just below the wrap point, and a wrap on the same edge as a clear, show that the status bit is both sticky and protected from the clear. A counter write on the same edge as an event shows that the write wins. Narrow and wide accesses to the counter slots separate the two halves of a counter and the upper bits that read as zero.

// File: rtl/evcnt_pkg.sv
package evcnt_pkg;
    localparam int          CODE_W    = 8;
    localparam int          NUM_EVT   = 1 << CODE_W;
    localparam logic [7:0]  CODE_NONE = 8'hFF;
    localparam int          RUN_POS   = 17;
    localparam logic [15:0] A_CTRL    = 16'h0408;
    localparam logic [15:0] A_MASK    = 16'h0800;
    localparam logic [15:0] A_STAT    = 16'h0808;
    localparam logic [15:0] A_CLR     = 16'h080C;
    localparam logic [15:0] A_EN      = 16'h1C00;
    localparam logic [15:0] A_SEL     = 16'h1D00;
    localparam logic [15:0] A_CNT     = 16'h1E00;
endpackage

// File: rtl/evcnt_dec.sv
module evcnt_dec #(
    parameter int N  = 8,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [15:0]   addr_i,
    input  logic          wide_i,
    output logic          lo_o,
    output logic          hi_o,
    output logic [IW-1:0] idx_o
);
    import evcnt_pkg::*;

    localparam logic [15:0] SPAN = 16'(8 * N);

    logic [15:0] off;
    logic        in_range;

    always_comb begin
        off      = addr_i - A_CNT;
        in_range = (addr_i >= A_CNT) && (off < SPAN) && (off[1:0] == 2'b00);
        idx_o    = off[3 +: IW];
        if (wide_i) begin
            lo_o = in_range && !off[2];
            hi_o = in_range && !off[2];
        end else begin
            lo_o = in_range && !off[2];
            hi_o = in_range &&  off[2];
        end
    end
endmodule

// File: rtl/evcnt_regs.sv
module evcnt_regs #(
    parameter int N = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_i,
    input  logic [15:0]    addr_i,
    input  logic [31:0]    wdata_i,
    input  logic [N-1:0]   ovf_i,
    output logic           run_o,
    output logic [N-1:0]   en_o,
    output logic [N-1:0]   mask_o,
    output logic [N*8-1:0] sel_o,
    output logic [N-1:0]   status_o,
    output logic           rd_hit_o,
    output logic [31:0]    rd_data_o
);
    import evcnt_pkg::*;

    localparam int NSEL = (N + 3) / 4;

    typedef struct packed {
        logic               run;
        logic [N-1:0]       en;
        logic [N-1:0]       mask;
        logic [N-1:0][7:0]  sel;
        logic [N-1:0]       status;
    } regs_t;

    regs_t       st_d, st_q;
    logic [N-1:0] clr_d;

    always_comb begin
        st_d  = st_q;
        clr_d = '0;
        if (wr_i) begin
            if (addr_i == A_CTRL) st_d.run  = wdata_i[RUN_POS];
            if (addr_i == A_EN)   st_d.en   = wdata_i[N-1:0];
            if (addr_i == A_MASK) st_d.mask = wdata_i[N-1:0];
            if (addr_i == A_CLR)  clr_d     = wdata_i[N-1:0];
            for (int k = 0; k < NSEL; k++) begin
                if (addr_i == A_SEL + 16'(k * 4)) begin
                    for (int j = 0; j < 4; j++) begin
                        if (k * 4 + j < N) st_d.sel[k*4+j] = wdata_i[8*j +: 8];
                    end
                end
            end
        end
        st_d.status = (st_q.status & ~clr_d) | ovf_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.run    <= 1'b0;
            st_q.en     <= '0;
            st_q.mask   <= '1;
            st_q.sel    <= '1;
            st_q.status <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rd_hit_o  = 1'b0;
        rd_data_o = '0;
        if (addr_i == A_CTRL) begin
            rd_hit_o           = 1'b1;
            rd_data_o[RUN_POS] = st_q.run;
        end
        if (addr_i == A_EN) begin
            rd_hit_o         = 1'b1;
            rd_data_o[N-1:0] = st_q.en;
        end
        if (addr_i == A_MASK) begin
            rd_hit_o         = 1'b1;
            rd_data_o[N-1:0] = st_q.mask;
        end
        if (addr_i == A_STAT) begin
            rd_hit_o         = 1'b1;
            rd_data_o[N-1:0] = st_q.status;
        end
        for (int k = 0; k < NSEL; k++) begin
            if (addr_i == A_SEL + 16'(k * 4)) begin
                rd_hit_o = 1'b1;
                for (int j = 0; j < 4; j++) begin
                    if (k * 4 + j < N) rd_data_o[8*j +: 8] = st_q.sel[k*4+j];
                end
            end
        end
    end

    assign run_o    = st_q.run;
    assign en_o     = st_q.en;
    assign mask_o   = st_q.mask;
    assign sel_o    = st_q.sel;
    assign status_o = st_q.status;

    // R8
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_i != '0) |=> ((status_o & $past(ovf_i)) == $past(ovf_i)));

    // R8
    clr_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == A_CLR && ovf_i == '0) |=> ((status_o & $past(wdata_i[N-1:0])) == '0));
endmodule

// File: rtl/evcnt_slice.sv
module evcnt_slice #(
    parameter int CNT_W = 48
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        run_i,
    input  logic                        en_i,
    input  logic [evcnt_pkg::CODE_W-1:0] code_i,
    input  logic [evcnt_pkg::NUM_EVT-1:0] evt_i,
    input  logic                        wr_lo_i,
    input  logic                        wr_hi_i,
    input  logic [31:0]                 lo_data_i,
    input  logic [CNT_W-33:0]           hi_data_i,
    output logic [CNT_W-1:0]            cnt_o,
    output logic                        ovf_o
);
    import evcnt_pkg::*;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } slice_t;

    slice_t st_d, st_q;
    logic   inc;

    always_comb begin
        inc   = run_i && en_i && (code_i != CODE_NONE) && evt_i[code_i];
        st_d  = st_q;
        ovf_o = 1'b0;
        if (wr_lo_i || wr_hi_i) begin
            if (wr_lo_i) st_d.cnt[31:0]       = lo_data_i;
            if (wr_hi_i) st_d.cnt[CNT_W-1:32] = hi_data_i;
        end else if (inc) begin
            {ovf_o, st_d.cnt} = {1'b0, st_q.cnt} + {{CNT_W{1'b0}}, 1'b1};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;

    // R4
    cnt_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !wr_lo_i && !wr_hi_i) |=> $stable(cnt_o));

    // R7
    wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |=> (cnt_o == '0));

    // R10
    wr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lo_i && wr_hi_i) |=> (cnt_o == $past({hi_data_i, lo_data_i})));
endmodule

// File: rtl/evcnt_bank.sv
module evcnt_bank #(
    parameter int NUM_CNT = 8,
    parameter int CNT_W   = 48
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          bus_valid_i,
    input  logic                          bus_write_i,
    input  logic                          bus_wide_i,
    input  logic [15:0]                   bus_addr_i,
    input  logic [63:0]                   bus_wdata_i,
    output logic [63:0]                   bus_rdata_o,
    input  logic [evcnt_pkg::NUM_EVT-1:0] evt_i,
    output logic                          irq_o
);
    import evcnt_pkg::*;

    localparam int IW = (NUM_CNT > 1) ? $clog2(NUM_CNT) : 1;
    localparam int HW = CNT_W - 32;

    logic                   bus_wr;
    logic                   dec_lo, dec_hi;
    logic [IW-1:0]          dec_idx;
    logic                   run;
    logic [NUM_CNT-1:0]     en, mask, status, ovf, wr_lo, wr_hi;
    logic [NUM_CNT*8-1:0]   sel;
    logic                   reg_hit;
    logic [31:0]            reg_data;
    logic [CNT_W-1:0]       cnt [NUM_CNT];
    logic [HW-1:0]          hi_data;
    logic                   unused_wdata;

    assign bus_wr       = bus_valid_i && bus_write_i;
    assign hi_data      = bus_wide_i ? bus_wdata_i[CNT_W-1:32] : bus_wdata_i[HW-1:0];
    assign unused_wdata = ^bus_wdata_i[63:CNT_W];

    evcnt_dec #(.N(NUM_CNT), .IW(IW)) u_dec (
        .addr_i (bus_addr_i),
        .wide_i (bus_wide_i),
        .lo_o   (dec_lo),
        .hi_o   (dec_hi),
        .idx_o  (dec_idx)
    );

    evcnt_regs #(.N(NUM_CNT)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (bus_wr),
        .addr_i    (bus_addr_i),
        .wdata_i   (bus_wdata_i[31:0]),
        .ovf_i     (ovf),
        .run_o     (run),
        .en_o      (en),
        .mask_o    (mask),
        .sel_o     (sel),
        .status_o  (status),
        .rd_hit_o  (reg_hit),
        .rd_data_o (reg_data)
    );

    for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
        assign wr_lo[g] = bus_wr && dec_lo && (dec_idx == IW'(g));
        assign wr_hi[g] = bus_wr && dec_hi && (dec_idx == IW'(g));

        evcnt_slice #(.CNT_W(CNT_W)) u_slice (
            .clk       (clk),
            .rst_n     (rst_n),
            .run_i     (run),
            .en_i      (en[g]),
            .code_i    (sel[8*g +: 8]),
            .evt_i     (evt_i),
            .wr_lo_i   (wr_lo[g]),
            .wr_hi_i   (wr_hi[g]),
            .lo_data_i (bus_wdata_i[31:0]),
            .hi_data_i (hi_data),
            .cnt_o     (cnt[g]),
            .ovf_o     (ovf[g])
        );
    end

    always_comb begin
        bus_rdata_o = '0;
        if (reg_hit) begin
            bus_rdata_o[31:0] = reg_data;
        end else if (dec_lo && dec_hi) begin
            bus_rdata_o[CNT_W-1:0] = cnt[dec_idx];
        end else if (dec_lo) begin
            bus_rdata_o[31:0] = cnt[dec_idx][31:0];
        end else if (dec_hi) begin
            bus_rdata_o[HW-1:0] = cnt[dec_idx][CNT_W-1:32];
        end
    end

    assign irq_o = |(status & ~mask);

    // R9
    irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !bus_wr) |=> irq_o);

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> (status != '0));
endmodule

// File: tb/tb_evcnt_bank.sv
module tb_evcnt_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid_i = 1'b0;
    logic        bus_write_i = 1'b0;
    logic        bus_wide_i = 1'b0;
    logic [15:0] bus_addr_i = '0;
    logic [63:0] bus_wdata_i = '0;
    logic [63:0] bus_rdata_o;
    logic [255:0] evt_i = '0;
    logic        irq_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    localparam logic [63:0] MAX48 = 64'h0000_FFFF_FFFF_FFFF;

    evcnt_bank dut (
        .clk(clk), .rst_n(rst_n),
        .bus_valid_i(bus_valid_i), .bus_write_i(bus_write_i), .bus_wide_i(bus_wide_i),
        .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o),
        .evt_i(evt_i), .irq_o(irq_o)
    );

    always #10 clk = ~clk;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [63:0] d, input logic wide);
        bus_valid_i = 1'b1; bus_write_i = 1'b1; bus_wide_i = wide;
        bus_addr_i = a; bus_wdata_i = d;
        @(negedge clk);
        bus_valid_i = 1'b0; bus_write_i = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, input logic wide, output logic [63:0] d);
        bus_valid_i = 1'b1; bus_write_i = 1'b0; bus_wide_i = wide; bus_addr_i = a;
        #1 d = bus_rdata_o;
        @(negedge clk);
        bus_valid_i = 1'b0;
    endtask

    task automatic rdchk(input string tag, input logic [15:0] a, input logic wide, input logic [63:0] exp);
        logic [63:0] v;
        rd(a, wide, v);
        chk(tag, v, exp);
    endtask

    task automatic hold(input int code, input int cycles);
        evt_i[code] = 1'b1;
        repeat (cycles) @(negedge clk);
        evt_i = '0;
    endtask

    task automatic t_reset();
        for (int n = 0; n < 8; n++) rdchk("R1 counter", 16'h1E00 + 16'(8*n), 1'b1, 64'h0);
        rdchk("R1 ctrl", 16'h0408, 1'b0, 64'h0);
        rdchk("R1 enable", 16'h1C00, 1'b0, 64'h0);
        rdchk("R1 mask", 16'h0800, 1'b0, 64'hFF);
        rdchk("R1 sel0", 16'h1D00, 1'b0, 64'hFFFF_FFFF);
        rdchk("R1 sel1", 16'h1D04, 1'b0, 64'hFFFF_FFFF);
        rdchk("R1 status", 16'h0808, 1'b0, 64'h0);
        chk("R1 irq", {63'b0, irq_o}, 64'h0);
    endtask

    task automatic t_select_count();
        wr(16'h1D00, 64'hFFFF_2210, 1'b0);
        wr(16'h1D04, 64'h07FF_FFFF, 1'b0);
        wr(16'h1C00, 64'h83, 1'b0);
        wr(16'h0408, 64'h2_0000, 1'b0);
        rdchk("R4 run readback", 16'h0408, 1'b0, 64'h2_0000);
        hold(8'h10, 5);
        hold(8'h22, 3);
        hold(8'h07, 2);
        rdchk("R3 ctr0 lane0", 16'h1E00, 1'b1, 64'd5);
        rdchk("R3 ctr1 lane1", 16'h1E08, 1'b1, 64'd3);
        rdchk("R3 ctr7 reg1 lane3", 16'h1E38, 1'b1, 64'd2);
        rdchk("R5 ctr2 disabled", 16'h1E10, 1'b1, 64'd0);
    endtask

    task automatic t_run_gate();
        wr(16'h0408, 64'h0, 1'b0);
        hold(8'h10, 4);
        rdchk("R4 ctr0 frozen", 16'h1E00, 1'b1, 64'd5);
        wr(16'h0408, 64'h2_0000, 1'b0);
    endtask

    task automatic t_enable();
        wr(16'h1C00, 64'h82, 1'b0);
        hold(8'h10, 3);
        rdchk("R5 ctr0 enable clear", 16'h1E00, 1'b1, 64'd5);
        wr(16'h1C00, 64'h87, 1'b0);
    endtask

    task automatic t_none();
        evt_i = '1;
        repeat (2) @(negedge clk);
        evt_i = '0;
        rdchk("R6 ctr2 code none", 16'h1E10, 1'b1, 64'd0);
        rdchk("R3 ctr0 all strobes", 16'h1E00, 1'b1, 64'd7);
    endtask

    task automatic t_slot();
        wr(16'h1E18, 64'hFFFF_1234_5678_9ABC, 1'b1);
        rdchk("R2 upper zero", 16'h1E18, 1'b1, 64'h0000_1234_5678_9ABC);
        rdchk("R2 narrow high", 16'h1E1C, 1'b0, 64'h0000_1234);
        rdchk("R2 narrow low", 16'h1E18, 1'b0, 64'h5678_9ABC);
        wr(16'h1E1C, 64'hABCD_0055, 1'b0);
        rdchk("R2 narrow high write", 16'h1E18, 1'b1, 64'h0000_0055_5678_9ABC);
        wr(16'h1E18, 64'h1111_2222, 1'b0);
        rdchk("R2 narrow low write", 16'h1E18, 1'b1, 64'h0000_0055_1111_2222);
    endtask

    task automatic t_ovf();
        wr(16'h0800, 64'hFE, 1'b0);
        wr(16'h1E00, MAX48 - 64'd1, 1'b1);
        hold(8'h10, 1);
        rdchk("R7 at top", 16'h1E00, 1'b1, MAX48);
        rdchk("R7 no status yet", 16'h0808, 1'b0, 64'h0);
        chk("R9 irq idle", {63'b0, irq_o}, 64'h0);
        hold(8'h10, 1);
        rdchk("R7 wrap to zero", 16'h1E00, 1'b1, 64'h0);
        rdchk("R7 status set", 16'h0808, 1'b0, 64'h1);
        chk("R9 irq raised", {63'b0, irq_o}, 64'h1);
        wr(16'h0800, 64'hFF, 1'b0);
        chk("R9 irq masked", {63'b0, irq_o}, 64'h0);
        wr(16'h0800, 64'hFE, 1'b0);
        chk("R9 irq unmasked", {63'b0, irq_o}, 64'h1);
        wr(16'h080C, 64'h0, 1'b0);
        rdchk("R8 zero clears nothing", 16'h0808, 1'b0, 64'h1);
        wr(16'h080C, 64'h1, 1'b0);
        rdchk("R8 status cleared", 16'h0808, 1'b0, 64'h0);
        chk("R9 irq dropped", {63'b0, irq_o}, 64'h0);
    endtask

    task automatic t_race();
        wr(16'h1E00, MAX48, 1'b1);
        hold(8'h10, 1);
        wr(16'h1E00, MAX48, 1'b1);
        evt_i[8'h10] = 1'b1;
        wr(16'h080C, 64'h1, 1'b0);
        evt_i = '0;
        rdchk("R8 overflow beats clear", 16'h0808, 1'b0, 64'h1);
        rdchk("R7 wrapped under clear", 16'h1E00, 1'b1, 64'h0);
        wr(16'h080C, 64'h1, 1'b0);
    endtask

    task automatic t_prio();
        evt_i[8'h10] = 1'b1;
        wr(16'h1E00, 64'd100, 1'b1);
        evt_i = '0;
        rdchk("R10 write wins", 16'h1E00, 1'b1, 64'd100);
        hold(8'h10, 1);
        rdchk("R10 counts after", 16'h1E00, 1'b1, 64'd101);
    endtask

    task automatic t_unmapped();
        rdchk("R11 addr 0", 16'h0000, 1'b1, 64'h0);
        rdchk("R11 addr 1234", 16'h1234, 1'b0, 64'h0);
        rdchk("R11 clear reg", 16'h080C, 1'b0, 64'h0);
        rdchk("R11 slot 8", 16'h1E40, 1'b1, 64'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_select_count();
        t_run_gate();
        t_enable();
        t_none();
        t_slot();
        t_ovf();
        t_race();
        t_prio();
        t_unmapped();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule